// File: doc/BRIEF.md
# SPI Data Buffer with Trigger Levels

This block sits between a register data port and an SPI shifter. It holds two byte-wide FIFOs of 32 entries each, one per direction. Software or a DMA engine writes bytes into the transmit FIFO. The shifter pops them one at a time. Bytes the shifter receives are pushed into the receive FIFO. They are read out either one byte at a time or four bytes at once. A four-byte read can reorder the bytes for DMA.

A control byte sets the trigger threshold for each direction and carries one flush bit per FIFO. The transmit request is raised when the free space reaches the selected level. The receive request is raised when the stored count reaches the selected level. An overrun flag records a receive push that was lost because the FIFO was full.

A small state machine tracks whether transmission has ended. It has three states:
- TX_IDLE: the FIFO is empty and the shifter is idle.
- TX_HOLD: the FIFO holds data.
- TX_DRAIN: the FIFO is empty but the shifter is still sending its last frame.

The state machine has five transitions:
- IDLE→HOLD when the FIFO becomes non-empty.
- HOLD→DRAIN when the FIFO empties while the shifter is busy.
- HOLD→IDLE when the FIFO empties while the shifter is idle.
- DRAIN→HOLD when new data arrives.
- DRAIN→IDLE when the shifter goes idle.

The state advances on the registered fill count, so the transmit-end flag follows the buffer one cycle later.

Top module: `spi_byte_buffer`

## Requirements
- R1: After reset both fill counts are 0 and status reads 8'h60. That is: receive request (bit7) 0, transmit end (bit6) 1, transmit request (bit5) 1, overrun (bit0) 0.
- R2: Bytes leave each FIFO in the order they entered.
  - The transmit head is on `sh_txdata` and is removed by `sh_pop`.
  - The receive head is on `rx_rdata` and is removed by `rx_rd`.
- R3: A write to the transmit FIFO while it holds 32 bytes is dropped. The count stays 32 and the stored bytes are unchanged.
- R4: Transmit trigger code `ctl_wdata[5:4]` sets the minimum free space needed for the transmit request (status bit5):
  - 00 = 1 byte
  - 01 = 8 bytes
  - 10 = 16 bytes
  - 11 = 32 bytes
- R5: Receive trigger code `ctl_wdata[2:0]` sets the minimum stored count needed for the receive request (status bit7). Code 000 needs 1 byte. Any other code c needs (c+1)*4 bytes, so 111 needs 32.
- R6: Overrun (status bit0) behaves as follows:
  - It is set by a shifter push while the receive FIFO holds 32 bytes. That byte is discarded.
  - Writing 0 through `stat_wr`/`stat_ovr_wval` clears it.
  - Writing 1 leaves it unchanged.
- R7: While control bit7 is 1, the transmit FIFO is emptied and held empty, and writes to it are ignored. The flush takes effect at the edge the control word is written. Writing 0 resumes normal operation. The receive FIFO is untouched.
- R8: Control bit6 does the same for the receive FIFO, and leaves the transmit FIFO untouched.
- R9: Transmit end (status bit6) follows the three-state machine above.
  - It falls once the FIFO holds data.
  - It stays low while the FIFO is empty and `sh_busy` is high.
  - It returns high when both are idle.
- R10: `dma_rdata` assembles the four oldest receive bytes b0..b3. The byte orders are:
  - {b3,b2,b1,b0} with no swap.
  - {b2,b3,b0,b1} with `swap_bytes`.
  - {b1,b0,b3,b2} with `swap_words`.
  - {b0,b1,b2,b3} with both.
  
  `dma_rd` removes four bytes and is ignored when fewer than four are stored.
- R11: `tx_count` and `rx_count` report the current fill levels, from 0 to 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte: [7] tx flush, [6] rx flush, [5:4] tx trigger, [2:0] rx trigger |
| stat_wr | input | 1 | Write strobe for the status overrun bit |
| stat_ovr_wval | input | 1 | Value written to the overrun bit; 0 clears it |
| swap_bytes | input | 1 | Swap bytes within each 16-bit half of `dma_rdata` |
| swap_words | input | 1 | Swap the 16-bit halves of `dma_rdata` |
| tx_wr | input | 1 | Push `tx_wdata` into the transmit FIFO |
| tx_wdata | input | 8 | Transmit data byte |
| rx_rd | input | 1 | Remove one byte from the receive FIFO |
| rx_rdata | output | 8 | Oldest receive byte |
| dma_rd | input | 1 | Remove four bytes from the receive FIFO |
| dma_rdata | output | 32 | Four oldest receive bytes, reordered per swap inputs |
| status | output | 8 | [7] rx request, [6] tx end, [5] tx request, [0] overrun, others 0 |
| tx_count | output | 6 | Bytes held in the transmit FIFO |
| rx_count | output | 6 | Bytes held in the receive FIFO |
| sh_pop | input | 1 | Shifter takes the transmit head |
| sh_txdata | output | 8 | Transmit head byte for the shifter |
| sh_tx_valid | output | 1 | Transmit FIFO is non-empty |
| sh_busy | input | 1 | Shifter is sending a frame |
| sh_push | input | 1 | Shifter delivers a received byte |
| sh_rxdata | input | 8 | Received byte from the shifter |

## Verification
The bench drives both FIFOs to exactly full and then pushes once more. A design that let the pointer wrap would report a count of 0 or overwrite the oldest byte. A design that did not flag the lost byte would leave overrun clear.

The threshold table covers the extremes of each trigger field (0, 1, 31 and 32 bytes) and the interior codes right at their levels. An off-by-one comparison shows up as a request raised one byte early or late.

The flush tests check the following:
- The other FIFO keeps its contents.
- A write issued while the flush bit is held is dropped.
- Writing 1 to overrun does not clear it.

The transmit-end test holds the shifter busy after the last pop. A design that watched only the fill count would raise transmit end too early. Each of the four DMA swap settings is compared against its expected byte order.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_HOLD  = 2'd1,
        TX_DRAIN = 2'd2
    } txend_state_e;

    localparam int CTL_TXFLUSH = 7;
    localparam int CTL_RXFLUSH = 6;
    localparam int ST_RXREQ    = 7;
    localparam int ST_TXEND    = 6;
    localparam int ST_TXREQ    = 5;
    localparam int ST_OVR      = 0;
    localparam int DMA_LANES   = 4;
    localparam int BYTE_W      = 8;
endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 8,
    parameter int PEEK  = 4,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        push,
    input  logic [WIDTH-1:0]            wdata,
    input  logic                        pop_one,
    input  logic                        pop_many,
    output logic [CW-1:0]               cnt,
    output logic [PEEK-1:0][WIDTH-1:0]  peek
);
    localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
    localparam logic [CW-1:0] PEEK_N = CW'(PEEK);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    pop_amt;
    logic             do_push;

    always_comb begin
        do_push = push && !flush && (cnt_q != FULL_N);
        if (pop_many && (cnt_q >= PEEK_N)) begin
            pop_amt = PEEK_N;
        end else if (pop_one && (cnt_q != '0)) begin
            pop_amt = CW'(1);
        end else begin
            pop_amt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(do_push);
            rd_ptr <= rd_ptr + pop_amt[AW-1:0];
            cnt_q  <= cnt_q + CW'(do_push) - pop_amt;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    for (genvar g = 0; g < PEEK; g++) begin : g_peek
        assign peek[g] = mem[rd_ptr + AW'(g)];
    end

    assign cnt = cnt_q;

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_N);

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == FULL_N) && !pop_one && !pop_many && !flush) |=> (cnt_q == FULL_N));
endmodule

// File: rtl/sbuf_swap.sv
module sbuf_swap #(
    parameter int W = 8
) (
    input  logic [3:0][W-1:0] lanes,
    input  logic              swap_b,
    input  logic              swap_w,
    output logic [4*W-1:0]    word
);
    logic [2*W-1:0] half_lo;
    logic [2*W-1:0] half_hi;

    always_comb begin
        half_lo = swap_b ? {lanes[0], lanes[1]} : {lanes[1], lanes[0]};
        half_hi = swap_b ? {lanes[2], lanes[3]} : {lanes[3], lanes[2]};
        word    = swap_w ? {half_lo, half_hi} : {half_hi, half_lo};
    end
endmodule

// File: rtl/sbuf_txend.sv
module sbuf_txend
    import sbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic buf_empty,
    input  logic sh_busy,
    output logic tx_end
);
    txend_state_e state_q;
    txend_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (!buf_empty) state_d = TX_HOLD;
            end
            TX_HOLD: begin
                if (buf_empty) state_d = sh_busy ? TX_DRAIN : TX_IDLE;
            end
            TX_DRAIN: begin
                if (!buf_empty)   state_d = TX_HOLD;
                else if (!sh_busy) state_d = TX_IDLE;
            end
            default: state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        tx_end = (state_q == TX_IDLE);
    end

    // R9
    tx_end_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end) |-> $past(buf_empty && !sh_busy));

    // R9
    drain_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_empty && sh_busy && !tx_end) |=> !tx_end);
endmodule

// File: rtl/spi_byte_buffer.sv
module spi_byte_buffer
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ctl_wr,
    input  logic [7:0]                    ctl_wdata,
    input  logic                          stat_wr,
    input  logic                          stat_ovr_wval,
    input  logic                          swap_bytes,
    input  logic                          swap_words,
    input  logic                          tx_wr,
    input  logic [BYTE_W-1:0]             tx_wdata,
    input  logic                          rx_rd,
    output logic [BYTE_W-1:0]             rx_rdata,
    input  logic                          dma_rd,
    output logic [DMA_LANES*BYTE_W-1:0]   dma_rdata,
    output logic [7:0]                    status,
    output logic [CW-1:0]                 tx_count,
    output logic [CW-1:0]                 rx_count,
    input  logic                          sh_pop,
    output logic [BYTE_W-1:0]             sh_txdata,
    output logic                          sh_tx_valid,
    input  logic                          sh_busy,
    input  logic                          sh_push,
    input  logic [BYTE_W-1:0]             sh_rxdata
);
    localparam logic [CW-1:0] FULL_N = CW'(DEPTH);

    logic [7:0]    ctl_q;
    logic          tx_flush;
    logic          rx_flush;
    logic [CW-1:0] tx_cnt;
    logic [CW-1:0] rx_cnt;
    logic [CW-1:0] tx_thr;
    logic [CW-1:0] rx_thr;
    logic          rx_lost;
    logic          ovr_q;
    logic          tx_req;
    logic          rx_req;
    logic          tx_end;
    logic          ctl_unused;
    logic [0:0][BYTE_W-1:0]           tx_peek;
    logic [DMA_LANES-1:0][BYTE_W-1:0] rx_peek;

    assign ctl_unused = ctl_wdata[3];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= ctl_wdata;
        end
    end

    assign tx_flush = ctl_wr ? ctl_wdata[CTL_TXFLUSH] : ctl_q[CTL_TXFLUSH];
    assign rx_flush = ctl_wr ? ctl_wdata[CTL_RXFLUSH] : ctl_q[CTL_RXFLUSH];

    sbuf_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W), .PEEK(1)) i_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (tx_flush),
        .push     (tx_wr),
        .wdata    (tx_wdata),
        .pop_one  (sh_pop),
        .pop_many (1'b0),
        .cnt      (tx_cnt),
        .peek     (tx_peek)
    );

    sbuf_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W), .PEEK(DMA_LANES)) i_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (rx_flush),
        .push     (sh_push),
        .wdata    (sh_rxdata),
        .pop_one  (rx_rd),
        .pop_many (dma_rd),
        .cnt      (rx_cnt),
        .peek     (rx_peek)
    );

    sbuf_swap #(.W(BYTE_W)) i_swap (
        .lanes  (rx_peek),
        .swap_b (swap_bytes),
        .swap_w (swap_words),
        .word   (dma_rdata)
    );

    sbuf_txend i_txend (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_empty (tx_cnt == '0),
        .sh_busy   (sh_busy),
        .tx_end    (tx_end)
    );

    always_comb begin
        unique case (ctl_q[5:4])
            2'd0:    tx_thr = CW'(1);
            2'd1:    tx_thr = CW'(DEPTH / 4);
            2'd2:    tx_thr = CW'(DEPTH / 2);
            default: tx_thr = FULL_N;
        endcase
        if (ctl_q[2:0] == 3'd0) begin
            rx_thr = CW'(1);
        end else begin
            rx_thr = CW'((int'(ctl_q[2:0]) + 1) * DEPTH / 8);
        end
    end

    assign tx_req  = (FULL_N - tx_cnt) >= tx_thr;
    assign rx_req  = rx_cnt >= rx_thr;
    assign rx_lost = sh_push && !rx_flush && (rx_cnt == FULL_N);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (rx_lost) begin
            ovr_q <= 1'b1;
        end else if (stat_wr && !stat_ovr_wval) begin
            ovr_q <= 1'b0;
        end
    end

    always_comb begin
        status           = '0;
        status[ST_RXREQ] = rx_req;
        status[ST_TXEND] = tx_end;
        status[ST_TXREQ] = tx_req;
        status[ST_OVR]   = ovr_q;
    end

    assign tx_count    = tx_cnt;
    assign rx_count    = rx_cnt;
    assign sh_txdata   = tx_peek[0];
    assign sh_tx_valid = (tx_cnt != '0);
    assign rx_rdata    = rx_peek[0];

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_push && !rx_flush && (rx_cnt == FULL_N)) |=> status[ST_OVR]);

    // R6
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !stat_ovr_wval && !(sh_push && rx_cnt == FULL_N)) |=> !status[ST_OVR]);

    // R5
    rx_req_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[ST_RXREQ] |-> (rx_count != '0));

    // R4
    tx_req_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == FULL_N) |-> !status[ST_TXREQ]);

    // R10
    dma_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd && (rx_cnt >= CW'(DMA_LANES)) && !rx_flush && !sh_push)
            |=> (rx_count == $past(rx_cnt) - CW'(DMA_LANES)));
endmodule

// File: tb/test_spi_byte_buffer.sv
module test_spi_byte_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 0, stat_wr = 0, stat_ovr_wval = 0;
    logic [7:0]  ctl_wdata = 0;
    logic        swap_bytes = 0, swap_words = 0;
    logic        tx_wr = 0, rx_rd = 0, dma_rd = 0;
    logic [7:0]  tx_wdata = 0;
    logic [7:0]  rx_rdata;
    logic [31:0] dma_rdata;
    logic [7:0]  status;
    logic [5:0]  tx_count, rx_count;
    logic        sh_pop = 0, sh_busy = 0, sh_push = 0;
    logic [7:0]  sh_txdata, sh_rxdata = 0;
    logic        sh_tx_valid;
    int          nchk = 0;
    int          nfail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    spi_byte_buffer i_spi_byte_buffer (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .stat_wr(stat_wr), .stat_ovr_wval(stat_ovr_wval),
        .swap_bytes(swap_bytes), .swap_words(swap_words),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .dma_rd(dma_rd), .dma_rdata(dma_rdata), .status(status),
        .tx_count(tx_count), .rx_count(rx_count), .sh_pop(sh_pop),
        .sh_txdata(sh_txdata), .sh_tx_valid(sh_tx_valid), .sh_busy(sh_busy),
        .sh_push(sh_push), .sh_rxdata(sh_rxdata)
    );

    // {ctl, fill count, expected tx request, expected rx request}
    localparam logic [15:0] VEC [14] = '{
        {8'h00, 6'd0,  1'b1, 1'b0},
        {8'h00, 6'd1,  1'b1, 1'b1},
        {8'h00, 6'd31, 1'b1, 1'b1},
        {8'h00, 6'd32, 1'b0, 1'b1},
        {8'h37, 6'd0,  1'b1, 1'b0},
        {8'h37, 6'd1,  1'b0, 1'b0},
        {8'h37, 6'd31, 1'b0, 1'b0},
        {8'h37, 6'd32, 1'b0, 1'b1},
        {8'h11, 6'd8,  1'b1, 1'b1},
        {8'h11, 6'd7,  1'b1, 1'b0},
        {8'h23, 6'd16, 1'b1, 1'b1},
        {8'h23, 6'd17, 1'b0, 1'b1},
        {8'h16, 6'd25, 1'b0, 1'b0},
        {8'h16, 6'd28, 1'b0, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ctl_write(input logic [7:0] v);
        ctl_wdata = v; ctl_wr = 1; step(); ctl_wr = 0;
    endtask

    task automatic tx_put(input logic [7:0] b);
        tx_wdata = b; tx_wr = 1; step(); tx_wr = 0;
    endtask

    task automatic rx_put(input logic [7:0] b);
        sh_rxdata = b; sh_push = 1; step(); sh_push = 0;
    endtask

    task automatic flush_both();
        ctl_write(8'hC0); ctl_write(8'h00);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1
        check("R1 status", {24'd0, status}, 32'h60);
        check("R1 tx_count", {26'd0, tx_count}, 0);
        check("R1 rx_count", {26'd0, rx_count}, 0);

        // R4 R5 R11 threshold table
        for (int v = 0; v < 14; v++) begin
            ctl_write(VEC[v][15:8] | 8'hC0);
            ctl_write(VEC[v][15:8]);
            for (int i = 0; i < int'(VEC[v][7:2]); i++) begin
                tx_wdata = 8'(i); sh_rxdata = 8'(i);
                tx_wr = 1; sh_push = 1; step();
            end
            tx_wr = 0; sh_push = 0;
            check("R11 tx_count", {26'd0, tx_count}, {26'd0, VEC[v][7:2]});
            check("R11 rx_count", {26'd0, rx_count}, {26'd0, VEC[v][7:2]});
            check("R4 tx_req", {31'd0, status[5]}, {31'd0, VEC[v][1]});
            check("R5 rx_req", {31'd0, status[7]}, {31'd0, VEC[v][0]});
        end

        // R2 ordering
        flush_both();
        tx_put(8'hA1); tx_put(8'hB2); tx_put(8'hC3);
        rx_put(8'h5A); rx_put(8'h6B);
        check("R2 tx head0", {24'd0, sh_txdata}, 32'hA1);
        sh_pop = 1; step(); sh_pop = 0;
        check("R2 tx head1", {24'd0, sh_txdata}, 32'hB2);
        sh_pop = 1; step(); sh_pop = 0;
        check("R2 tx head2", {24'd0, sh_txdata}, 32'hC3);
        check("R2 rx head0", {24'd0, rx_rdata}, 32'h5A);
        rx_rd = 1; step(); rx_rd = 0;
        check("R2 rx head1", {24'd0, rx_rdata}, 32'h6B);

        // R3 tx full
        flush_both();
        for (int i = 0; i < 32; i++) tx_put(8'(8'h40 + i));
        tx_put(8'hEE);
        check("R3 tx_count full", {26'd0, tx_count}, 32);
        check("R4 tx_req full", {31'd0, status[5]}, 0);
        for (int i = 0; i < 32; i++) begin
            check("R3 tx data", {24'd0, sh_txdata}, 32'(8'h40 + i));
            sh_pop = 1; step(); sh_pop = 0;
        end
        check("R3 tx empty", {26'd0, tx_count}, 0);

        // R6 overrun
        flush_both();
        for (int i = 0; i < 32; i++) rx_put(8'(i));
        rx_put(8'h99);
        check("R6 ovr set", {31'd0, status[0]}, 1);
        check("R6 rx_count", {26'd0, rx_count}, 32);
        stat_ovr_wval = 1; stat_wr = 1; step(); stat_wr = 0;
        check("R6 ovr write1 keeps", {31'd0, status[0]}, 1);
        stat_ovr_wval = 0; stat_wr = 1; step(); stat_wr = 0;
        check("R6 ovr cleared", {31'd0, status[0]}, 0);
        for (int i = 0; i < 32; i++) begin
            check("R6 rx data", {24'd0, rx_rdata}, 32'(i));
            rx_rd = 1; step(); rx_rd = 0;
        end
        check("R6 rx drained", {26'd0, rx_count}, 0);

        // R7 tx flush
        flush_both();
        tx_put(8'h01); tx_put(8'h02); tx_put(8'h03);
        rx_put(8'h0A); rx_put(8'h0B);
        ctl_write(8'h80);
        check("R7 tx flushed", {26'd0, tx_count}, 0);
        check("R7 rx kept", {26'd0, rx_count}, 2);
        tx_put(8'h55);
        check("R7 write ignored", {26'd0, tx_count}, 0);
        ctl_write(8'h00);
        tx_put(8'h66);
        check("R7 resumed", {26'd0, tx_count}, 1);
        check("R7 data", {24'd0, sh_txdata}, 32'h66);

        // R8 rx flush
        ctl_write(8'h40);
        check("R8 rx flushed", {26'd0, rx_count}, 0);
        check("R8 tx kept", {26'd0, tx_count}, 1);
        rx_put(8'h44);
        check("R8 push ignored", {26'd0, rx_count}, 0);
        ctl_write(8'h00);
        rx_put(8'h77);
        check("R8 resumed", {26'd0, rx_count}, 1);
        check("R8 data", {24'd0, rx_rdata}, 32'h77);

        // R9 transmit end
        flush_both();
        step();
        check("R9 idle high", {31'd0, status[6]}, 1);
        tx_put(8'h12);
        step();
        check("R9 low with data", {31'd0, status[6]}, 0);
        sh_busy = 1; sh_pop = 1; step(); sh_pop = 0;
        step(); step();
        check("R9 low while busy", {31'd0, status[6]}, 0);
        sh_busy = 0; step();
        check("R9 high after idle", {31'd0, status[6]}, 1);

        // R10 DMA read and swaps
        flush_both();
        rx_put(8'h11); rx_put(8'h22); rx_put(8'h33); rx_put(8'h44);
        swap_bytes = 0; swap_words = 0; step();
        check("R10 no swap", dma_rdata, 32'h44332211);
        swap_bytes = 1; swap_words = 0; step();
        check("R10 byte swap", dma_rdata, 32'h33441122);
        swap_bytes = 0; swap_words = 1; step();
        check("R10 word swap", dma_rdata, 32'h22114433);
        swap_bytes = 1; swap_words = 1; step();
        check("R10 both swaps", dma_rdata, 32'h11223344);
        swap_bytes = 0; swap_words = 0;
        dma_rd = 1; step(); dma_rd = 0;
        check("R10 dma pop", {26'd0, rx_count}, 0);
        rx_put(8'h01); rx_put(8'h02); rx_put(8'h03);
        dma_rd = 1; step(); dma_rd = 0;
        check("R10 short ignored", {26'd0, rx_count}, 3);

        done = 1;
        summary();
        $finish;
    end
endmodule